// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block is an asynchronous serial transmitter. A holding register sits in front of the frame shifter, so the host can queue the next word while the current frame is still on the line. Each frame is a low start bit, then 7, 8 or 9 data bits least significant first, then an optional parity bit, then one or two high stop bits. The bit time is the system clock divided by a programmable prescaler of `brg_div + 1` and then by a fixed 16.

When flow control is on, a new frame may begin only while the active-low `cts_n` input is low. This is tested at the point where the previous stop bit finishes. If `cts_n` is high there, the line rests high and the queued word waits until `cts_n` drops. One sticky interrupt flag is raised on a selectable event, either when the holding register hands its word to the shifter or when the line falls silent after a frame. Frame format and divider inputs are static configuration and are sampled when a frame is loaded.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A frame is a start bit at 0, the data bits with bit 0 first, the parity bit when `parity_en` is 1, and then the stop bits at 1. The start bit appears on `txd` in the cycle after the load.
- R2: `data_len` selects the data width: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits (`wr_data[8:0]`), and 3 behaves as 8 bits.
- R3: Every bit, including start, parity and stop bits, lasts exactly 16 × (`brg_div` + 1) clock cycles.
- R4: A write (`wr_en` = 1) makes `buf_empty` 0 from the next cycle. When the word moves into the shifter without a write in the same cycle, `buf_empty` is 1 from the next cycle.
- R5: `tx_empty` is 0 from the cycle after a load until the last stop bit ends with no following frame. A queued word that is allowed to go starts in the cycle right after the previous stop bit, with no idle gap.
- R6: With `flow_en` = 1, no frame starts while `cts_n` is 1, and the line stays high. The waiting word starts at the first clock edge where `cts_n` is 0.
- R7: With `flow_en` = 0, `cts_n` has no effect on when frames start.
- R8: With `irq_sel` = 0, `irq` is set when the holding register hands a word to the shifter. With `irq_sel` = 1, `irq` is set when a frame ends and no new frame follows.
- R9: `irq` stays 1 until `irq_ack` is 1. A set event in the same cycle as an acknowledge leaves `irq` at 1.
- R10: With `tx_en` = 0, the frame in flight completes, but no new frame starts even when a word is waiting.
- R11: The parity bit makes the number of ones over the configured data bits plus the parity bit even when `parity_odd` = 0, and odd when `parity_odd` = 1.
- R12: `txd` is 1 whenever no frame is in flight.
- R13: A write while the holding register is full replaces the waiting word, and `buf_empty` stays 0.
- R14: After reset, `txd` = 1, `buf_empty` = 1, `tx_empty` = 1 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock of the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_div | input | DIV_W | Prescaler value n; the bit time is 16 × (n + 1) clocks |
| data_len | input | 2 | Data width select: 0 = 7, 1 = 8, 2 = 9, 3 = 8 |
| parity_en | input | 1 | Append a parity bit when 1 |
| parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| flow_en | input | 1 | Gate frame starts with `cts_n` when 1 |
| cts_n | input | 1 | Active-low clear-to-send, synchronous to `clk` |
| tx_en | input | 1 | Transmit enable; 0 blocks new frames |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to queue; unused upper bits are ignored |
| irq_sel | input | 1 | Interrupt event: 0 = holding register emptied, 1 = line went idle |
| irq_ack | input | 1 | Clears `irq` |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | 1 when the holding register can take a word |
| tx_empty | output | 1 | 1 when no frame is in flight |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is a clear-to-send stall that lands exactly on a stop-bit boundary while a word is already queued. The stimulus queues two words with `cts_n` low, then raises `cts_n` in the middle of the first frame. That leaves the second word waiting with the line idle, and the bench checks both flags before releasing `cts_n`. Two further cases need deliberate ordering from the ports: a write that overwrites a waiting word while the transmitter is disabled, and an acknowledge held high across a load. A behavioural model with a bit queue follows every clock, and a line decoder recovers the data and parity bits at the bit centres.

// File: rtl/uart_tx_dbuf.sv
`timescale 1ns/1ps
module uart_tx_dbuf #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] brg_div,
  input  logic [1:0]       data_len,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             two_stop,
  input  logic             flow_en,
  input  logic             cts_n,
  input  logic             tx_en,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  input  logic             irq_sel,
  input  logic             irq_ack,
  output logic             txd,
  output logic             buf_empty,
  output logic             tx_empty,
  output logic             irq
);
  localparam int FRAME_W = 13;
  localparam int SUB_W   = 4;

  logic               hold_full;
  logic [8:0]         hold_data;
  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [3:0]         bits_left;
  logic [DIV_W-1:0]   pre_cnt;
  logic [SUB_W-1:0]   sub_cnt;

  logic               bit_end, frame_done, cts_ok, load, irq_set, pbit;
  logic [3:0]         dlen, nbits;
  logic [8:0]         dmask;
  logic [FRAME_W-1:0] frame;

  assign bit_end    = busy && (pre_cnt == brg_div) && (sub_cnt == {SUB_W{1'b1}});
  assign frame_done = bit_end && (bits_left == 4'd1);
  assign cts_ok     = !flow_en || !cts_n;
  assign load       = hold_full && tx_en && cts_ok && (!busy || frame_done);
  assign irq_set    = irq_sel ? (frame_done && !load) : load;

  always_comb begin
    case (data_len)
      2'd0:    begin dlen = 4'd7; dmask = 9'h07F; end
      2'd2:    begin dlen = 4'd9; dmask = 9'h1FF; end
      default: begin dlen = 4'd8; dmask = 9'h0FF; end
    endcase
  end

  assign pbit  = (^(hold_data & dmask)) ^ parity_odd;
  assign nbits = 4'd2 + dlen + {3'b0, parity_en} + {3'b0, two_stop};

  always_comb begin
    frame       = '1;
    frame[0]    = 1'b0;
    frame[9:1]  = (hold_data & dmask) | ~dmask;
    if (parity_en) begin
      case (data_len)
        2'd0:    frame[8]  = pbit;
        2'd2:    frame[10] = pbit;
        default: frame[9]  = pbit;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      pre_cnt   <= '0;
      sub_cnt   <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      shreg     <= frame;
      bits_left <= nbits;
      pre_cnt   <= '0;
      sub_cnt   <= '0;
    end else if (busy) begin
      if (pre_cnt == brg_div) begin
        pre_cnt <= '0;
        sub_cnt <= sub_cnt + SUB_W'(1);
      end else begin
        pre_cnt <= pre_cnt + DIV_W'(1);
      end
      if (bit_end) begin
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - 4'd1;
        if (frame_done) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_full <= 1'b1;
        hold_data <= wr_data;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (irq_set)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  assign txd       = busy ? shreg[0] : 1'b1;
  assign buf_empty = !hold_full;
  assign tx_empty  = !busy;

  // R4
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);
  // R4
  load_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> buf_empty);
  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!txd && !tx_empty));
  // R3
  bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(txd));
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  // R10
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_en) |=> (tx_empty && txd));
  // R6
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && flow_en && cts_n) |=> (tx_empty && txd));
endmodule

// File: tb/uart_tx_dbuf_tb_top.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] brg_div = 8'd0;
  logic [1:0] data_len = 2'd1;
  logic       parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
  logic       flow_en = 1'b0, cts_n = 1'b1, tx_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       irq_sel = 1'b0, irq_ack = 1'b0;
  logic       txd, buf_empty, tx_empty, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_tx_dbuf #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .brg_div(brg_div), .data_len(data_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .two_stop(two_stop),
    .flow_en(flow_en), .cts_n(cts_n), .tx_en(tx_en), .wr_en(wr_en),
    .wr_data(wr_data), .irq_sel(irq_sel), .irq_ack(irq_ack),
    .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: a queue of line levels per frame
  bit       m_busy, m_full, m_irq;
  bit [8:0] m_data;
  bit       m_q[$];
  int       m_cyc, m_bl;
  bit       m_bend, m_done, m_load, m_set;

  function automatic void build_frame(input bit [8:0] d);
    int nd, ones;
    nd = (data_len == 2'd0) ? 7 : (data_len == 2'd2) ? 9 : 8;
    ones = 0;
    m_q.delete();
    m_q.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      m_q.push_back(d[i]);
      ones += int'(d[i]);
    end
    if (parity_en) m_q.push_back(((ones % 2) == 1) ^ parity_odd);
    m_q.push_back(1'b1);
    if (two_stop) m_q.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_irq = 0; m_data = '0; m_cyc = 0;
      m_q.delete();
    end else begin
      m_bl   = 16 * (int'(brg_div) + 1);
      m_bend = m_busy && (m_cyc == m_bl - 1);
      m_done = m_bend && (m_q.size() == 1);
      m_load = m_full && tx_en && (!flow_en || !cts_n) && (!m_busy || m_done);
      m_set  = irq_sel ? (m_done && !m_load) : m_load;
      if (m_busy) begin
        if (m_bend) begin
          void'(m_q.pop_front());
          m_cyc = 0;
          if (m_done) m_busy = 0;
        end else m_cyc++;
      end
      if (m_load) begin
        build_frame(m_data);
        m_busy = 1;
        m_cyc  = 0;
      end
      if (wr_en) begin
        m_full = 1;
        m_data = wr_data;
      end else if (m_load) m_full = 0;
      if (m_set) m_irq = 1;
      else if (irq_ack) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit et = m_busy ? m_q[0] : 1'b1;
      chk(txd === et, "R1 R2 R3 R6 R7 R10 R11 R12 R13 txd", int'(txd), int'(et));
      chk(buf_empty === !m_full, "R4 R13 buf_empty", int'(buf_empty), int'(!m_full));
      chk(tx_empty === !m_busy, "R5 tx_empty", int'(tx_empty), int'(!m_busy));
      chk(irq === m_irq, "R8 R9 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic write_word(input bit [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy || m_full);
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic rx(input int nd, input bit par, output int d, output bit p);
    int bl;
    bl = 16 * (int'(brg_div) + 1);
    d = 0; p = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bl / 2) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      repeat (bl) @(negedge clk);
      d = d | (int'(txd) << i);
    end
    if (par) begin
      repeat (bl) @(negedge clk);
      p = txd;
    end
  endtask

  initial begin
    int d;
    bit p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R14 txd after reset", int'(txd), 1);
    chk(buf_empty === 1'b1, "R14 buf_empty after reset", int'(buf_empty), 1);
    chk(tx_empty === 1'b1, "R14 tx_empty after reset", int'(tx_empty), 1);
    chk(irq === 1'b0, "R14 irq after reset", int'(irq), 0);

    // 8N1, interrupt on buffer empty
    write_word(9'h0A5);
    @(negedge clk); tx_en = 1'b1;
    rx(8, 1'b0, d, p);
    chk(d == 'hA5, "R1 data bits", d, 'hA5);
    wait_idle();
    chk(irq === 1'b1, "R8 irq on buffer empty", int'(irq), 1);
    pulse_ack();
    chk(irq === 1'b0, "R9 irq cleared by ack", int'(irq), 0);

    // back-to-back frames
    write_word(9'h03C);
    write_word(9'h0C3);
    wait_idle();
    pulse_ack();

    // 9 data bits, two stops, slower clock, interrupt on completion
    brg_div = 8'd1; data_len = 2'd2; two_stop = 1'b1; irq_sel = 1'b1;
    write_word(9'h1A5);
    rx(9, 1'b0, d, p);
    chk(d == 'h1A5, "R2 nine-bit data", d, 'h1A5);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq === 1'b1, "R8 irq on completion", int'(irq), 1);
    pulse_ack();

    // 7 bits odd parity, then 8 bits even parity
    brg_div = 8'd0; data_len = 2'd0; two_stop = 1'b0; parity_en = 1'b1; parity_odd = 1'b1;
    write_word(9'h055);
    rx(7, 1'b1, d, p);
    chk(d == 'h55, "R2 seven-bit data", d, 'h55);
    chk(p == 1'b1, "R11 odd parity", int'(p), 1);
    wait_idle();
    data_len = 2'd1; parity_odd = 1'b0;
    write_word(9'h007);
    rx(8, 1'b1, d, p);
    chk(p == 1'b1, "R11 even parity", int'(p), 1);
    wait_idle();
    parity_en = 1'b0;

    // flow control holds the first frame
    flow_en = 1'b1; cts_n = 1'b1;
    write_word(9'h081);
    repeat (300) @(negedge clk);
    chk(tx_empty === 1'b1, "R6 held by cts tx_empty", int'(tx_empty), 1);
    chk(buf_empty === 1'b0, "R6 held by cts buf_empty", int'(buf_empty), 0);
    chk(txd === 1'b1, "R6 R12 line high while held", int'(txd), 1);
    cts_n = 1'b0;
    rx(8, 1'b0, d, p);
    chk(d == 'h81, "R6 released frame data", d, 'h81);
    wait_idle();

    // stall at the stop-bit boundary with a word queued
    write_word(9'h042);
    write_word(9'h024);
    repeat (50) @(negedge clk);
    cts_n = 1'b1;
    repeat (400) @(negedge clk);
    chk(tx_empty === 1'b1, "R6 stalled after stop tx_empty", int'(tx_empty), 1);
    chk(buf_empty === 1'b0, "R6 stalled word still queued", int'(buf_empty), 0);
    cts_n = 1'b0;
    wait_idle();

    // flow control off: cts ignored
    flow_en = 1'b0; cts_n = 1'b1;
    write_word(9'h099);
    repeat (3) @(negedge clk);
    chk(tx_empty === 1'b0, "R7 frame starts with cts_n high", int'(tx_empty), 0);
    wait_idle();

    // disable mid-frame with a word waiting
    write_word(9'h010);
    write_word(9'h020);
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    repeat (600) @(negedge clk);
    chk(tx_empty === 1'b1, "R10 no new frame when disabled", int'(tx_empty), 1);
    chk(buf_empty === 1'b0, "R10 word kept when disabled", int'(buf_empty), 0);

    // overwrite the waiting word
    write_word(9'h02C);
    chk(buf_empty === 1'b0, "R13 still full after overwrite", int'(buf_empty), 0);
    @(negedge clk); tx_en = 1'b1;
    rx(8, 1'b0, d, p);
    chk(d == 'h2C, "R13 overwritten word sent", d, 'h2C);
    wait_idle();

    // acknowledge held across a load: set wins
    irq_sel = 1'b0;
    pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    write_word(9'h001);
    @(negedge clk);
    irq_ack = 1'b0;
    wait_idle();

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule